// File: doc/BRIEF.md
# Synchronous Flow-Through Burst Cache SRAM

This block is a single-ported synchronous cache memory with a 32-bit data word split into four byte lanes. Its depth is a parameter. On every rising clock it samples the address, three chip selects, two address strobes, a burst-advance input and the write controls. It then classifies the cycle as a burst start, a burst step, a burst hold or a deselect. One strobe is meant for a processor and the other for an external cache controller. A two-bit wrapping counter supplies the low address bits during a burst. The word order is linear or interleaved, chosen when the burst starts.

Reads are flow-through: the word addressed at a clock edge appears on the output after that edge, with no extra pipeline stage. Writes can be full-word or byte-masked. The shared bus is modelled as three signals: an output word, an output-drive flag and an input word. The drive flag rises only for a read cycle while the asynchronous output enable is low. It stays low through every write, so the bus floats even when output enable is asserted.

Top module: `burst_sram`

## Requirements
- R1: The block counts as selected only when `ce1N`=0, `ce2`=1 and `ce3N`=0 at the clock edge. A strobe cycle that is not fully selected is a deselect: nothing is written, the burst ends and `dataOe` is 0 for the following cycle.
- R2: A burst started by `adspN`=0 (with `ce1N`=0) is always a read, whatever `gwN`, `bweN` and `bwN` are.
- R3: After a processor-strobe start, the write controls are honoured from the next clock. A write request on a following hold cycle (`advN`=1) stores `dataIn` at the burst's start address.
- R4: A burst started by `adscN`=0 while `adspN`=1 writes `dataIn` at once if the write controls request a write. Otherwise it is a read.
- R5: With `ce1N`=1, `adspN` is ignored. `adscN`=0 is then a deselect, and `adscN`=1 continues or holds the active burst.
- R6: `gwN`=0 writes all four lanes, whatever `bweN` and `bwN` are.
- R7: With `gwN`=1 and `bweN`=0, lane n (bits 8n+7..8n) is written when `bwN[n]`=0. `bweN`=1, or `bwN`=4'b1111, makes the cycle a read.
- R8: With both strobes high inside a burst, `advN`=0 steps to the next burst position k (counter k=0..3). The low address bits are (start + k) mod 4 when `burstInterleave` was 0 at the burst start, and start XOR k when it was 1. The address wraps within its group of four words.
- R9: With both strobes high inside a burst, `advN`=1 holds the current address for a read or a write.
- R10: `dataOe` is 1 only in a read cycle with `oeN`=0, and it follows `oeN` within the same cycle without a clock. After any write cycle it is 0, even when `oeN`=0.
- R11: After reset `dataOe` is 0 and no burst is active. A cycle with both strobes high and no active burst writes nothing and leaves the bus floating.
- R12: A read's word, at address {upper address bits, burst offset}, is on `dataOut` after the very edge that samples the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| addrIn | input | ADDR_W | Word address sampled at a burst start |
| ce1N | input | 1 | Chip select 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip select 2, active high |
| ce3N | input | 1 | Chip select 3, active low |
| adspN | input | 1 | Processor address strobe, active low |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte write enable, active low |
| bwN | input | 4 | Byte lane selects, active low, bit n controls lane n |
| oeN | input | 1 | Asynchronous output enable, active low |
| burstInterleave | input | 1 | Burst order at the start: 1 interleaved, 0 linear |
| dataIn | input | 32 | Bus word seen by the block as input |
| dataOut | output | 32 | Bus word the block would drive |
| dataOe | output | 1 | Block drives the bus when 1 |

## Verification
A wrong counter or burst-order state shows up as the wrong word on `dataOut`. This happens in the first cycle after the faulty step, because reads are flow-through and every step is read back at once. A wrong write classification, such as a processor-strobe start that writes or a lane mask that is off by one, is hidden until that address is read again. For this reason, each write scenario is followed by a readback burst. A stale read-valid state appears as `dataOe` high on the cycle after a write or a deselect. The comparison against the model catches it in that same cycle.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = LANES * 8;
  localparam int OFF_W  = 2;

  typedef struct packed {
    logic             load;
    logic             advance;
    logic             write;
    logic             read;
    logic             desel;
    logic [LANES-1:0] mask;
  } strobe_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  output strobe_t          strb
);
  logic selected;
  logic procStart;
  logic burstActive;
  logic [LANES-1:0] reqMask;

  assign selected  = !ce1N && ce2 && !ce3N;
  assign procStart = !adspN && !ce1N;

  always_comb begin
    if (!gwN)       reqMask = '1;
    else if (!bweN) reqMask = ~bwN;
    else            reqMask = '0;
  end

  always_comb begin
    strb = '0;
    if (rstN) begin
      if (procStart) begin
        if (selected) begin
          strb.load = 1'b1;
          strb.read = 1'b1;
        end else begin
          strb.desel = 1'b1;
        end
      end else if (!adscN) begin
        if (selected) begin
          strb.load  = 1'b1;
          strb.write = |reqMask;
          strb.read  = ~|reqMask;
          strb.mask  = reqMask;
        end else begin
          strb.desel = 1'b1;
        end
      end else if (burstActive) begin
        strb.advance = !advN;
        strb.write   = |reqMask;
        strb.read    = ~|reqMask;
        strb.mask    = reqMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           burstActive <= 1'b0;
    else if (strb.load)  burstActive <= 1'b1;
    else if (strb.desel) burstActive <= 1'b0;
  end

  // R2: a processor-strobe start never writes
  assert_adsp_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && !ce1N && !gwN) |-> (!strb.write && !strb.mask[0]));

  // R1: a strobe without full selection starts nothing
  assert_desel_noload_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!(!ce1N && ce2 && !ce3N) && (!adscN || (!adspN && !ce1N)))
      |-> (!strb.load && !strb.write));

  // R11: no burst, no strobe -> no action
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!burstActive && adscN && (adspN || ce1N)) |-> (!strb.write && !strb.read));
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              burstInterleave,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int UP_W  = ADDR_W - OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [UP_W-1:0]   upperQ;
  logic [OFF_W-1:0]  baseQ;
  logic [OFF_W-1:0]  cntQ;
  logic              modeQ;
  logic              rdValidQ;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nextAddr;

  function automatic logic [OFF_W-1:0] orderOff(input logic il,
      input logic [OFF_W-1:0] b, input logic [OFF_W-1:0] k);
    return il ? (b ^ k) : (b + k);
  endfunction

  assign curAddr = {upperQ, orderOff(modeQ, baseQ, cntQ)};

  always_comb begin
    if (strb.load)         nextAddr = addrIn;
    else if (strb.advance) nextAddr = {upperQ, orderOff(modeQ, baseQ, cntQ + 2'd1)};
    else                   nextAddr = curAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ   <= '0;
      baseQ    <= '0;
      cntQ     <= '0;
      modeQ    <= 1'b0;
      rdValidQ <= 1'b0;
    end else begin
      if (strb.load) begin
        upperQ <= addrIn[ADDR_W-1:OFF_W];
        baseQ  <= addrIn[OFF_W-1:0];
        cntQ   <= '0;
        modeQ  <= burstInterleave;
      end else if (strb.advance) begin
        cntQ <= cntQ + 2'd1;
      end
      rdValidQ <= strb.read;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.write) begin
      for (int l = 0; l < LANES; l++) begin
        if (strb.mask[l]) mem[nextAddr][l*8 +: 8] <= dataIn[l*8 +: 8];
      end
    end
  end

  assign dataOut = mem[curAddr];
  assign rdValid = rdValidQ;

  // R10: a write cycle leaves the bus undriven
  assert_write_float_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |=> !rdValidQ);

  // R1: deselect ends any read
  assert_desel_float_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.desel |=> !rdValidQ);

  // R9: a hold keeps the address
  assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.read || strb.write) && !strb.load && !strb.advance) |=> $stable(curAddr));

  // R8: linear step moves the offset by one, upper bits fixed
  assert_linear_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !modeQ) |=>
      (curAddr[OFF_W-1:0] == $past(curAddr[OFF_W-1:0]) + 2'd1) && $stable(upperQ));
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [3:0]        bwN,
  input  logic              oeN,
  input  logic              burstInterleave,
  input  logic [31:0]       dataIn,
  output logic [31:0]       dataOut,
  output logic              dataOe
);
  strobe_t strb;
  logic    rdValid;

  burst_sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .strb(strb)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn),
    .burstInterleave(burstInterleave), .dataIn(dataIn),
    .dataOut(dataOut), .rdValid(rdValid)
  );

  assign dataOe = rdValid && !oeN;

  // R10: never drives with output enable high
  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> !oeN);
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  addrIn = '0;
  logic        ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic        adspN = 1'b1, adscN = 1'b1, advN = 1'b1;
  logic        gwN = 1'b1, bweN = 1'b1;
  logic [3:0]  bwN = 4'hF;
  logic        oeN = 1'b0, burstInterleave = 1'b0;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic        dataOe;

  int checks = 0, errors = 0;
  bit done = 0;
  string curReq = "R11";

  // reference model state
  bit [31:0] refMem [int];
  bit        refActive = 0, refRd = 0, refMode = 0;
  int        refUpper = 0, refBase = 0, refCnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  burst_sram u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .oeN(oeN), .burstInterleave(burstInterleave), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic int refAddr();
    int off = refMode ? (refBase ^ refCnt) : ((refBase + refCnt) % 4);
    return refUpper * 4 + off;
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  task automatic compareNow();
    bit expOe = refRd && !oeN;
    int a = refAddr();
    check(dataOe == expOe, "dataOe", dataOe, expOe);
    if (expOe && refMem.exists(a)) check(dataOut == refMem[a], "dataOut", dataOut, refMem[a]);
  endtask

  task automatic modelEdge();
    bit sel = !ce1N && ce2 && !ce3N;
    bit [3:0] m;
    bit load = 0, adv = 0, wr = 0, rd = 0;
    if (!gwN) m = 4'hF; else if (!bweN) m = ~bwN; else m = 4'h0;
    if (!adspN && !ce1N) begin
      if (sel) begin load = 1; rd = 1; end else refActive = 0;
    end else if (!adscN) begin
      if (sel) begin load = 1; wr = (m != 0); rd = (m == 0); end else refActive = 0;
    end else if (refActive) begin
      adv = !advN; wr = (m != 0); rd = (m == 0);
    end
    if (load) begin
      refUpper = int'(addrIn) / 4; refBase = int'(addrIn) % 4;
      refCnt = 0; refMode = burstInterleave; refActive = 1;
    end else if (adv) refCnt = (refCnt + 1) % 4;
    if (wr) begin
      int a = refAddr();
      bit [31:0] w = refMem.exists(a) ? refMem[a] : 32'h0;
      for (int l = 0; l < 4; l++) if (m[l]) w[l*8 +: 8] = dataIn[l*8 +: 8];
      refMem[a] = w;
    end
    refRd = rd;
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    #2;
    compareNow();
  endtask

  task automatic idle();
    adspN = 1; adscN = 1; advN = 1; gwN = 1; bweN = 1; bwN = 4'hF;
    ce1N = 0; ce2 = 1; ce3N = 0;
  endtask

  task automatic deselect();
    idle(); ce2 = 0; adscN = 0; tick(); idle();
  endtask

  task automatic ctrlStart(input int a, input bit g, input bit be, input bit [3:0] b, input bit [31:0] d);
    idle(); addrIn = 10'(a); adscN = 0; gwN = g; bweN = be; bwN = b; dataIn = d; tick(); idle();
  endtask

  task automatic procStart(input int a);
    idle(); addrIn = 10'(a); adspN = 0; tick(); idle();
  endtask

  task automatic step(input bit advance, input bit g, input bit [31:0] d);
    idle(); advN = !advance; gwN = g; dataIn = d; tick(); idle();
  endtask

  initial begin
    // R11 reset
    repeat (3) @(posedge clk);
    #2; check(dataOe == 0, "reset dataOe", dataOe, 0);
    @(negedge clk); rstN = 1;
    curReq = "R11"; step(1, 0, 32'hBAD0_0001);   // no burst active: no write, floats

    // R4 controller-strobe writes then reads
    curReq = "R4";
    for (int i = 0; i < 4; i++) ctrlStart(16 + i, 0, 1, 4'hF, 32'h1000_0000 + i);
    for (int i = 0; i < 4; i++) ctrlStart(16 + i, 1, 1, 4'hF, 32'h0);
    curReq = "R12"; ctrlStart(17, 1, 1, 4'hF, 32'h0);

    // R2 processor start ignores write controls
    curReq = "R2";
    idle(); addrIn = 10'd18; adspN = 0; gwN = 0; dataIn = 32'hDEAD_BEEF; tick(); idle();
    ctrlStart(18, 1, 1, 4'hF, 0);

    // R3 processor start then write on hold cycle
    curReq = "R3";
    procStart(40);
    step(0, 0, 32'hA5A5_0040);
    procStart(40);

    // R8 linear burst write then reads from various starts
    curReq = "R8";
    burstInterleave = 0;
    ctrlStart(64, 0, 1, 4'hF, 32'h6400_0000);
    for (int i = 1; i < 4; i++) step(1, 0, 32'h6400_0000 + i);
    for (int s = 0; s < 4; s++) begin
      burstInterleave = s[0];
      procStart(64 + s);
      for (int k = 0; k < 5; k++) step(1, 1, 0);   // includes wrap
    end
    burstInterleave = 1;
    ctrlStart(128 + 2, 0, 1, 4'hF, 32'h8000_0002);
    for (int i = 0; i < 3; i++) step(1, 0, 32'h8000_0010 + i);
    burstInterleave = 0;
    procStart(128); for (int k = 0; k < 3; k++) step(1, 1, 0);

    // R9 hold mid burst
    curReq = "R9";
    procStart(65); step(1, 1, 0); step(0, 1, 0); step(0, 1, 0); step(1, 1, 0);

    // R6 / R7 byte lanes
    curReq = "R6";
    ctrlStart(200, 0, 0, 4'hA, 32'h1111_1111);
    ctrlStart(200, 0, 1, 4'h0, 32'hFFFF_FFFF);
    ctrlStart(200, 1, 1, 4'hF, 0);
    curReq = "R7";
    ctrlStart(200, 1, 0, 4'b1110, 32'h0000_0022);
    ctrlStart(200, 1, 0, 4'b0101, 32'h3300_4400);
    ctrlStart(200, 1, 1, 4'b0000, 32'h5555_5555);   // bwe high: read
    ctrlStart(200, 1, 0, 4'b1111, 32'h6666_6666);   // no lane: read
    ctrlStart(200, 1, 1, 4'hF, 0);

    // R1 deselect variants
    curReq = "R1";
    idle(); addrIn = 10'd16; ce2 = 0; adspN = 0; tick(); idle();
    idle(); addrIn = 10'd16; ce3N = 1; adscN = 0; gwN = 0; dataIn = 32'hBAD0_0002; tick(); idle();
    step(1, 0, 32'hBAD0_0003);                      // R11: no active burst
    ctrlStart(16, 1, 1, 4'hF, 0);

    // R5 processor strobe masked by ce1N
    curReq = "R5";
    procStart(64);
    idle(); ce1N = 1; adspN = 0; addrIn = 10'd300; advN = 0; tick(); idle();
    idle(); ce1N = 1; adspN = 0; addrIn = 10'd300; tick(); idle();
    idle(); ce1N = 1; adscN = 0; tick(); idle();
    step(1, 1, 0);

    // R10 output enable behaviour
    curReq = "R10";
    oeN = 0; ctrlStart(17, 0, 1, 4'hF, 32'h0A0A_0017);
    oeN = 1; ctrlStart(17, 1, 1, 4'hF, 0);
    oeN = 0; #1; compareNow();
    oeN = 1; #1; compareNow();
    oeN = 0; step(1, 0, 32'h0B0B_0017);
    step(1, 1, 0);
    deselect();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule